// File: doc/BRIEF.md
# Debug Serial Command Port

This block is the slave end of a three-wire serial link between an external debugger and an on-chip debug module. The debugger drives a serial clock and a serial data line into the chip and reads a serial data line back. The block never uses the serial clock as a clock. It samples both inputs with the fast core clock, accepts a serial clock level only once it has been stable for two core cycles, and acts on each accepted rising edge. On that edge it takes in one inbound bit and moves the outbound line to its next bit.

A frame has 17 bits and is sent most significant bit first. Inbound, the first bit is a control bit and the remaining 16 bits are a data word. When the last bit arrives, the block gives the debug logic the control bit and the word, with a one-cycle strobe. Outbound, the debug logic may load a word between frames. The next frame then returns a ready status bit followed by that word. If no word was loaded, the frame returns a not-ready status bit followed by zeros. The serial clock must run at no more than one fifth of the core clock rate.

Top module: `dbg_serial_port`

## Requirements
- R1: A synchronous reset (`rst` high) clears the bit counter, both shift registers and any pending transmit word, and drives `sdat_out` and `rx_valid` low. A frame begun before the reset is discarded.
- R2: A serial clock level is accepted only after two consecutive core-clock samples agree. A high pulse on `sclk_in` that lasts one core cycle shifts no bit.
- R3: Inbound bits are taken from `sdat_in` only on accepted rising edges of the serial clock. Falling edges and idle time shift nothing.
- R4: An inbound frame is 17 bits, MSB first. Bit 1 is presented on `rx_ctrl` and bits 2 to 17 on `rx_word[15:0]`, with bit 2 as `rx_word[15]`.
- R5: After the 17th accepted rising edge, `rx_valid` is high for exactly one core cycle. It is never high at any other time.
- R6: `sdat_out` comes from a register and changes only in the core cycle after an accepted rising edge. Between frames it holds its value.
- R7: If `tx_load` pulsed before a frame's first edge, the outbound frame is a status bit of 0 (ready) followed by the loaded `tx_word`, MSB first. Outbound bit k is on `sdat_out` after the k-th rising edge of the frame.
- R8: If no word is pending when a frame starts, the outbound frame is a status bit of 1 (not ready) followed by 16 zeros.
- R9: A loaded word is sent in exactly one frame. The next frame reports not ready unless `tx_load` pulses again. When several loads come before one frame, the last of them is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_in | input | 1 | Serial clock from the debugger (asynchronous) |
| sdat_in | input | 1 | Serial data from the debugger (asynchronous) |
| sdat_out | output | 1 | Registered serial data to the debugger |
| rx_valid | output | 1 | One-cycle strobe: an inbound frame is complete |
| rx_ctrl | output | 1 | Control bit of the last inbound frame |
| rx_word | output | 16 | Data word of the last inbound frame |
| tx_load | input | 1 | Load `tx_word` for the next outbound frame |
| tx_word | input | 16 | Word to return in the next frame |

## Verification
The hardest situation to reach from the ports is a serial clock pulse too short to be accepted. It must be ignored without disturbing the bit count of the frame around it. The bench raises `sclk_in` for exactly one core cycle in the middle of a frame and then finishes the frame. A word that is received intact, together with the correct outbound bits, shows that the glitch was not counted. The bench also asserts reset partway through a frame that is shifting out a loaded word. This shows that the partial frame and the pending word are both dropped.

// File: rtl/dbg_serial_port.sv
module dbg_serial_port #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_in,
  input  logic              sdat_in,
  output logic              sdat_out,
  output logic              rx_valid,
  output logic              rx_ctrl,
  output logic [DATA_W-1:0] rx_word,
  input  logic              tx_load,
  input  logic [DATA_W-1:0] tx_word
);
  localparam int FRAME_W = DATA_W + 1;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic              sclk_m, sclk_a, sclk_b, sclk_v;
  logic              dat_m, dat_a;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] rx_sh, tx_sh, tx_buf;
  logic              tx_pend;
  logic              rise, first, last;

  assign rise  = (sclk_a == sclk_b) && sclk_a && !sclk_v;
  assign first = (cnt == '0);
  assign last  = (cnt == CNT_W'(FRAME_W - 1));

  always_ff @(posedge clk) begin
    sclk_m <= sclk_in;
    sclk_a <= sclk_m;
    sclk_b <= sclk_a;
    dat_m  <= sdat_in;
    dat_a  <= dat_m;
    if (rst)
      sclk_v <= 1'b0;
    else if (sclk_a == sclk_b)
      sclk_v <= sclk_a;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      rx_sh    <= '0;
      rx_valid <= 1'b0;
      rx_ctrl  <= 1'b0;
      rx_word  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (rise) begin
        rx_sh <= {rx_sh[DATA_W-2:0], dat_a};
        if (last) begin
          cnt      <= '0;
          rx_valid <= 1'b1;
          rx_ctrl  <= rx_sh[DATA_W-1];
          rx_word  <= {rx_sh[DATA_W-2:0], dat_a};
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdat_out <= 1'b0;
      tx_sh    <= '0;
      tx_buf   <= '0;
      tx_pend  <= 1'b0;
    end else begin
      if (tx_load) begin
        tx_buf  <= tx_word;
        tx_pend <= 1'b1;
      end else if (rise && first) begin
        tx_pend <= 1'b0;
      end
      if (rise) begin
        if (first) begin
          sdat_out <= !tx_pend;
          tx_sh    <= tx_pend ? tx_buf : '0;
        end else begin
          sdat_out <= tx_sh[DATA_W-1];
          tx_sh    <= {tx_sh[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R5
  strobe_after_edge_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(rise));

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rise) && !$past(rst)) |-> $stable(sdat_out));

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(FRAME_W - 1));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!sdat_out && !rx_valid && cnt == '0));

  // R2
  edge_needs_two_chk: assert property (@(posedge clk) disable iff (rst)
    rise |-> (sclk_a && sclk_b));
endmodule

// File: tb/test_dbg_serial_port.sv
module test_dbg_serial_port;
  logic clk = 1'b0, rst = 1'b1;
  logic sclk_in = 1'b0, sdat_in = 1'b0, tx_load = 1'b0;
  logic [15:0] tx_word = '0;
  logic sdat_out, rx_valid, rx_ctrl;
  logic [15:0] rx_word;

  int checks = 0, fails = 0;
  logic [16:0] rx_q[$];
  logic        m_pend = 1'b0;
  logic [15:0] m_buf = '0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  dbg_serial_port i_dbg_serial_port (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .sdat_in(sdat_in),
    .sdat_out(sdat_out), .rx_valid(rx_valid), .rx_ctrl(rx_ctrl),
    .rx_word(rx_word), .tx_load(tx_load), .tx_word(tx_word));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: R4 R5
  always @(negedge clk) if (!rst && rx_valid) begin
    if (rx_q.size() == 0)
      check(1'b0, "R5 unexpected strobe", {15'b0, rx_ctrl, rx_word}, 32'h0);
    else begin
      logic [16:0] e;
      e = rx_q.pop_front();
      check({rx_ctrl, rx_word} == e, "R4 received frame", {15'b0, rx_ctrl, rx_word}, {15'b0, e});
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load(input logic [15:0] w);
    @(negedge clk);
    tx_load = 1'b1; tx_word = w;
    @(negedge clk);
    tx_load = 1'b0;
    m_pend = 1'b1; m_buf = w;
  endtask

  task automatic bit_xfer(input logic b, output logic o);
    sdat_in = b;
    wait_n(6);
    sclk_in = 1'b1;
    wait_n(6);
    o = sdat_out;
    sclk_in = 1'b0;
  endtask

  task automatic frame(input logic c, input logic [15:0] w, input string req, input bit glitch);
    logic [16:0] tx_exp, tx_got, d;
    logic o;
    tx_exp = m_pend ? {1'b0, m_buf} : {1'b1, 16'h0};
    m_pend = 1'b0;
    d = {c, w};
    rx_q.push_back(d);
    for (int k = 16; k >= 0; k--) begin
      bit_xfer(d[k], o);
      tx_got[k] = o;
      if (glitch && k == 9) begin
        wait_n(3);
        sclk_in = 1'b1; @(negedge clk); sclk_in = 1'b0;
        wait_n(3);
      end
    end
    wait_n(8);
    check(tx_got == tx_exp, req, {15'b0, tx_got}, {15'b0, tx_exp});
    check(rx_q.size() == 0, "R5 strobe count", rx_q.size(), 0);
  endtask

  initial begin
    fork begin
      repeat (150000) @(negedge clk);
      if (!done) begin
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end join_none

    wait_n(4);
    rst = 1'b0;
    wait_n(2);
    // R1
    check(sdat_out == 1'b0, "R1 reset sdat_out", sdat_out, 0);
    check(rx_valid == 1'b0, "R1 reset rx_valid", rx_valid, 0);

    // R8 nothing loaded
    frame(1'b1, 16'hA5C3, "R8 not-ready frame", 1'b0);
    // R7 loaded word
    load(16'h9E21);
    frame(1'b0, 16'h1234, "R7 loaded frame", 1'b0);
    // R9 consumed once
    frame(1'b0, 16'hFFFF, "R9 one-shot", 1'b0);
    // R9 last load wins
    load(16'h0F0F);
    load(16'h8001);
    frame(1'b1, 16'h0000, "R9 last load wins", 1'b0);
    // R6 output holds between frames
    begin
      logic held;
      held = sdat_out;
      wait_n(40);
      check(sdat_out == held, "R6 idle hold", sdat_out, held);
    end
    // R2 glitch inside frame is ignored
    load(16'h7FFE);
    frame(1'b1, 16'h5AA5, "R2 glitch ignored", 1'b1);
    // R3 falling edges and idle do nothing: slow bits
    frame(1'b0, 16'hC001, "R3 edges only", 1'b0);

    // R1 reset mid-frame drops partial frame and pending word
    load(16'hFFFF);
    begin
      logic o;
      for (int k = 0; k < 5; k++) bit_xfer(1'b1, o);
      check(o == 1'b1, "R7 partial shift", o, 1);
    end
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(sdat_out == 1'b0, "R1 mid-frame reset", sdat_out, 0);
    m_pend = 1'b0;
    frame(1'b1, 16'h3C3C, "R1 after reset frame", 1'b0);

    wait_n(10);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule